// File: doc/BRIEF.md
# Demagnetization-Gated PWM Cycle Sequencer

This block is the digital cycle engine of a current-mode switching controller. A counter stands in for the timing capacitor. It ramps up slowly from a valley to a peak, which is the charge phase, and then falls back quickly, which is the discharge phase. The gate drive may only be on during the charge phase. A conduction pulse is armed when each charge phase begins. It ends on the first of four events: a current-sense trip, the ramp passing the duty-limit level, the end of the charge phase, or loss of enable.

When a pulse ends, the transformer core is taken to be magnetized. The ramp may not start a new charge until the demagnetization comparator input has been seen low. If discharge finishes first, the ramp waits at the valley in a third hold state.

The first low seen on the demagnetization input is latched until the next pulse ends. Ringing on the winding after that first low therefore cannot stall the next cycle. Holding the demagnetization input low all the time leaves the ramp free-running.

Top module: `pwm_cycle_seq`

## Requirements
- R1: While reset is asserted, gate is 0. After reset the ramp starts its first charge from 0.
- R2: The ramp rises by UP_STEP per cycle from VALLEY to PEAK, then falls by DN_STEP per cycle back to VALLEY. gate can be 1 only in the charge phase. With the defaults and no other limit, each steady period is 50 cycles, with gate high for 40 of them.
- R3: gate is 0 in any cycle where the ramp value exceeds duty_lim. A steady pulse therefore lasts for the ramp values VALLEY through min(duty_lim, PEAK-1).
- R4: A cs_trip sampled at 1 while gate is 1 drives gate to 0 from the next cycle until the next charge phase. A cs_trip outside the charge phase has no effect.
- R5: After a pulse ends, the next charge does not start until demag_in has been 0 in a cycle with gate at 0. If discharge ends before that, the ramp holds at VALLEY and charge starts two cycles after the cycle in which demag_in is 0.
- R6: Once demag_in has been seen at 0 after a pulse, later returns of demag_in to 1 before the next pulse do not delay the next charge.
- R7: gate is 0 while the ramp value is below FLOOR. After reset, with no other limit, the first pulse begins FLOOR cycles after reset is released.
- R8: While en is 0, gate is 0 and the ramp stops at VALLEY after its discharge. Once en returns to 1, charge restarts on the next cycle.
- R9: With demag_in held at 0, the ramp is never stalled. Rising edges of gate follow one another every 50 cycles by default.
- R10: At most one pulse occurs per charge phase. If the duty limit ends a pulse and is then raised within the same charge, gate does not turn on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable. At 0 it forces gate off and prevents a new charge |
| cs_trip | input | 1 | Current-sense comparator trip, 1 = peak current reached |
| demag_in | input | 1 | Demagnetization comparator, 1 = winding above threshold (core still magnetized) |
| duty_lim | input | RW | Duty-limit level in ramp units (soft-start or maximum duty) |
| gate | output | 1 | Gate drive |

## Verification
The bench builds the block with its defaults: an 8-bit ramp, a valley of 32, a peak of 72, steps of 1 and 4, and a floor of 20. A steady period is then only 50 cycles, and the first period after reset is 82 cycles.

That short period makes it possible to sweep every duty-limit value from 0 to 80 and every current-trip offset across the charge phase. It also makes it possible to try every demagnetization release instant from inside the discharge phase to deep inside the valley hold.

Each run is checked cycle by cycle against a stepped model. It is also checked against closed-form pulse widths and rise instants computed from the parameters.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  typedef enum logic [1:0] {
    PH_CHARGE = 2'd0,
    PH_DISCH  = 2'd1,
    PH_HOLD   = 2'd2
  } phase_t;

  // Next ramp value while charging: one step up, saturating at the peak.
  function automatic int rise_step(int r, int up, int peak);
    return (r + up >= peak) ? peak : r + up;
  endfunction

  // Next ramp value while discharging: one step down, saturating at the valley.
  function automatic int fall_step(int r, int dn, int valley);
    return (r - dn <= valley) ? valley : r - dn;
  endfunction

endpackage

// File: rtl/pwm_ramp_osc.sv
module pwm_ramp_osc
  import pwm_seq_pkg::*;
#(
  parameter int RW      = 8,
  parameter int VALLEY  = 32,
  parameter int PEAK    = 72,
  parameter int UP_STEP = 1,
  parameter int DN_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  output logic [RW-1:0] ramp,
  output phase_t        phase,
  output logic          charge_start
);

  localparam logic [RW-1:0] VALLEY_V = RW'(VALLEY);
  localparam logic [RW-1:0] PEAK_V   = RW'(PEAK);

  int            up_v;
  int            dn_v;
  logic [RW-1:0] nxt_ramp;
  phase_t        nxt_phase;

  always_comb begin
    up_v      = rise_step(int'(ramp), UP_STEP, PEAK);
    dn_v      = fall_step(int'(ramp), DN_STEP, VALLEY);
    nxt_ramp  = ramp;
    nxt_phase = phase;
    case (phase)
      PH_CHARGE: begin
        nxt_ramp = RW'(up_v);
        if (RW'(up_v) == PEAK_V) nxt_phase = PH_DISCH;
      end
      PH_DISCH: begin
        nxt_ramp = RW'(dn_v);
        if (RW'(dn_v) == VALLEY_V) nxt_phase = ready ? PH_CHARGE : PH_HOLD;
      end
      PH_HOLD: begin
        nxt_ramp = VALLEY_V;
        if (ready) nxt_phase = PH_CHARGE;
      end
      default: begin
        nxt_ramp  = VALLEY_V;
        nxt_phase = PH_HOLD;
      end
    endcase
  end

  assign charge_start = (phase != PH_CHARGE) && (nxt_phase == PH_CHARGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp  <= '0;
      phase <= PH_CHARGE;
    end else begin
      ramp  <= nxt_ramp;
      phase <= nxt_phase;
    end
  end

endmodule

// File: rtl/pwm_demag_latch.sv
module pwm_demag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic demag_in,
  input  logic gate,
  input  logic gate_fall,
  output logic mag_pend
);

  // Set when a pulse ends (core holds energy). Cleared by the first low on
  // the comparator while the switch is off, then kept clear until the next
  // pulse ends, so ringing cannot re-arm it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mag_pend <= 1'b0;
    else if (gate_fall)         mag_pend <= 1'b1;
    else if (!gate && !demag_in) mag_pend <= 1'b0;
  end

endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl
  import pwm_seq_pkg::*;
#(
  parameter int RW    = 8,
  parameter int FLOOR = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_trip,
  input  logic [RW-1:0] duty_lim,
  input  logic [RW-1:0] ramp,
  input  phase_t        phase,
  input  logic          charge_start,
  input  logic          mag_pend,
  output logic          gate,
  output logic          gate_fall,
  output logic          armed
);

  localparam logic [RW-1:0] FLOOR_V = RW'(FLOOR);

  logic gate_q;
  logic in_charge;
  logic above_floor;
  logic within_lim;

  assign in_charge   = (phase == PH_CHARGE);
  assign above_floor = (ramp >= FLOOR_V);
  assign within_lim  = (ramp <= duty_lim);

  assign gate      = en && armed && in_charge && !mag_pend && above_floor && within_lim;
  assign gate_fall = gate_q && !gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (charge_start)                       armed <= 1'b1;
      else if ((in_charge && cs_trip) || gate_fall) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_cycle_seq.sv
module pwm_cycle_seq
  import pwm_seq_pkg::*;
#(
  parameter int RW      = 8,
  parameter int VALLEY  = 32,
  parameter int PEAK    = 72,
  parameter int UP_STEP = 1,
  parameter int DN_STEP = 4,
  parameter int FLOOR   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_trip,
  input  logic          demag_in,
  input  logic [RW-1:0] duty_lim,
  output logic          gate
);

  logic [RW-1:0] ramp;
  phase_t        phase;
  logic          charge_start;
  logic          mag_pend;
  logic          gate_fall;
  logic          armed;
  logic          ready;

  assign ready = en && !mag_pend;

  pwm_ramp_osc #(
    .RW(RW), .VALLEY(VALLEY), .PEAK(PEAK), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)
  ) u_osc (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .ramp(ramp), .phase(phase), .charge_start(charge_start)
  );

  pwm_demag_latch u_demag (
    .clk(clk), .rst_n(rst_n), .demag_in(demag_in),
    .gate(gate), .gate_fall(gate_fall), .mag_pend(mag_pend)
  );

  pwm_gate_ctl #(.RW(RW), .FLOOR(FLOOR)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .cs_trip(cs_trip),
    .duty_lim(duty_lim), .ramp(ramp), .phase(phase),
    .charge_start(charge_start), .mag_pend(mag_pend),
    .gate(gate), .gate_fall(gate_fall), .armed(armed)
  );

endmodule

// File: rtl/pwm_cycle_seq_chk.sv
module pwm_cycle_seq_chk
  import pwm_seq_pkg::*;
#(
  parameter int RW    = 8,
  parameter int PEAK  = 72,
  parameter int FLOOR = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_trip,
  input logic          gate,
  input logic [RW-1:0] ramp,
  input logic [RW-1:0] duty_lim,
  input phase_t        phase,
  input logic          mag_pend
);

  // R2
  charge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (phase == PH_CHARGE));

  // R2
  ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ramp) <= PEAK);

  // R3
  gate_le_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (ramp <= duty_lim));

  // R4
  trip_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_trip && gate) |=> !gate);

  // R5
  hold_while_magnetized_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && mag_pend) |=> (phase == PH_HOLD));

  // R7
  gate_above_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (int'(ramp) >= FLOOR));

  // R10
  no_second_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && phase == PH_CHARGE) |=> !gate);

endmodule

bind pwm_cycle_seq pwm_cycle_seq_chk #(.RW(RW), .PEAK(PEAK), .FLOOR(FLOOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_trip(cs_trip), .gate(gate), .ramp(ramp),
  .duty_lim(duty_lim), .phase(phase), .mag_pend(mag_pend)
);

// File: tb/tb_pwm_cycle_seq.sv
module tb_pwm_cycle_seq;

  localparam int RW = 8, VALLEY = 32, PEAK = 72, UP = 1, DN = 4, FLOOR = 20;
  localparam int CHG   = (PEAK - VALLEY + UP - 1) / UP;
  localparam int DIS   = (PEAK - VALLEY + DN - 1) / DN;
  localparam int PER   = CHG + DIS;
  localparam int FIRST = (PEAK + UP - 1) / UP + DIS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cs_trip = 1'b0, demag_in = 1'b0;
  logic [RW-1:0] duty_lim = '0;
  logic gate;

  always #4 clk = ~clk;

  pwm_cycle_seq #(.RW(RW), .VALLEY(VALLEY), .PEAK(PEAK), .UP_STEP(UP),
                  .DN_STEP(DN), .FLOOR(FLOOR)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cs_trip(cs_trip),
    .demag_in(demag_in), .duty_lim(duty_lim), .gate(gate));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";
  int m_r, m_ph, m_arm, m_mag, m_gq;

  function automatic int imin(int a, int b); return a < b ? a : b; endfunction
  function automatic int imax(int a, int b); return a > b ? a : b; endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; en = 0; cs_trip = 0; demag_in = 0; duty_lim = '0;
    #1 chk("R1", int'(gate), 0, "gate in reset");
    @(negedge clk);
    #1 chk("R1", int'(gate), 0, "gate in reset");
    @(negedge clk);
    rst_n = 1;
    m_r = 0; m_ph = 0; m_arm = 1; m_mag = 0; m_gq = 0;
  endtask

  // Drive one cycle, compare with stepped model, advance to the next negedge.
  task automatic step(input bit e, input bit cs, input bit dm, input int lim, output bit g);
    int ex, nr, nph;
    bit fall, rdy, cst;
    en = e; cs_trip = cs; demag_in = dm; duty_lim = RW'(lim);
    #1;
    ex = (e && m_ph == 0 && m_arm == 1 && m_mag == 0 && m_r >= FLOOR && m_r <= lim) ? 1 : 0;
    chk(tag, int'(gate), ex, "gate vs cycle model");
    g = gate;
    fall = (m_gq == 1) && (ex == 0);
    rdy = e && (m_mag == 0);
    nr = m_r; nph = m_ph;
    if (m_ph == 0) begin
      nr = imin(m_r + UP, PEAK);
      if (nr == PEAK) nph = 1;
    end else if (m_ph == 1) begin
      nr = imax(m_r - DN, VALLEY);
      if (nr == VALLEY) nph = rdy ? 0 : 2;
    end else begin
      nr = VALLEY;
      nph = rdy ? 0 : 2;
    end
    cst = (m_ph != 0) && (nph == 0);
    if (cst) m_arm = 1;
    else if ((m_ph == 0 && cs) || fall) m_arm = 0;
    if (fall) m_mag = 1;
    else if (ex == 0 && !dm) m_mag = 0;
    m_gq = ex; m_r = nr; m_ph = nph;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit g, pg;
    int rises[4];
    int nrise, h1, h2, h3, rise;

    // R2 / R7 / R9: free run, demag tied low, no limit
    tag = "R2";
    do_reset();
    nrise = 0; h2 = 0; pg = 0;
    for (int i = 0; i < 232; i++) begin
      step(1, 0, 0, 255, g);
      if (g && !pg && nrise < 4) begin rises[nrise] = i; nrise++; end
      if (g && i >= FIRST && i < FIRST + PER) h2++;
      pg = g;
    end
    chk("R7", rises[0], FLOOR, "first rise after reset");
    chk("R2", rises[1], FIRST, "second rise");
    chk("R2", h2, CHG, "steady pulse width");
    chk("R9", rises[2] - rises[1], PER, "period with demag tied low");
    chk("R9", rises[3] - rises[2], PER, "period with demag tied low");

    // R3: sweep every duty limit
    tag = "R3";
    for (int lim = 0; lim <= 80; lim++) begin
      do_reset();
      h1 = 0; h2 = 0;
      for (int i = 0; i < FIRST + PER; i++) begin
        step(1, 0, 0, lim, g);
        if (g) begin if (i < FIRST) h1++; else h2++; end
      end
      chk("R3", h1, imax(0, imin(lim, PEAK - 1) - FLOOR + 1), "first width vs limit");
      chk("R3", h2, imax(0, imin(lim, PEAK - 1) - VALLEY + 1), "steady width vs limit");
    end

    // R4: trip at every offset of the charge phase, extra trips ignored
    tag = "R4";
    for (int k = 1; k <= CHG; k++) begin
      do_reset();
      h2 = 0; h3 = 0;
      for (int i = 0; i < FIRST + 2 * PER; i++) begin
        bit cs;
        cs = (i == FIRST + k - 1) || (i >= FIRST + k + 2 && i < FIRST + k + 5) ||
             (i >= FIRST + CHG + 2 && i < FIRST + CHG + 7);
        step(1, cs, 0, 255, g);
        if (g && i >= FIRST && i < FIRST + PER) h2++;
        if (g && i >= FIRST + PER) h3++;
      end
      chk("R4", h2, k, "width after trip");
      chk("R4", h3, CHG, "next width after discharge trips");
    end

    // R5: demag released at each instant from discharge into valley hold
    tag = "R5";
    for (int s = FIRST + CHG + 1; s <= FIRST + CHG + 38; s++) begin
      do_reset();
      rise = -1; h2 = 0; pg = 0;
      for (int i = 0; i < 260; i++) begin
        step(1, 0, (i >= 100 && i < s), 255, g);
        if (g && !pg && i > FIRST + CHG && rise < 0) rise = i;
        if (g && rise >= 0 && i < rise + PER) h2++;
        pg = g;
      end
      chk("R5", rise, imax(FIRST + PER, s + 2), "restart after demag");
      chk("R5", h2, CHG, "width after stall");
    end

    // R6: ringing after the first low is ignored
    tag = "R6";
    do_reset();
    rise = -1; pg = 0;
    for (int i = 0; i < 200; i++) begin
      step(1, 0, (i >= 100 && i < 125) || (i >= 126), 255, g);
      if (g && !pg && i > FIRST + CHG && rise < 0) rise = i;
      pg = g;
    end
    chk("R6", rise, FIRST + PER, "restart despite ringing");

    // R8: enable low halts at valley, restart next cycle
    tag = "R8";
    do_reset();
    h1 = 0; rise = -1; pg = 0;
    for (int i = 0; i < 200; i++) begin
      step(i >= 150, 0, 0, 255, g);
      if (g && i < 150) h1++;
      if (g && !pg && rise < 0) rise = i;
      pg = g;
    end
    chk("R8", h1, 0, "gate while disabled");
    chk("R8", rise, 151, "rise after enable");

    // R10: limit dips mid-pulse then returns, no second pulse
    tag = "R10";
    do_reset();
    h2 = 0; h3 = 0;
    for (int i = 0; i < FIRST + 2 * PER; i++) begin
      step(1, 0, 0, (i >= FIRST + 10 && i < FIRST + 13) ? 0 : 255, g);
      if (g && i >= FIRST && i < FIRST + PER) h2++;
      if (g && i >= FIRST + PER) h3++;
    end
    chk("R10", h2, 10, "width with dip");
    chk("R10", h3, CHG, "next width");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule